// File: doc/BRIEF.md
# Checkpoint Group Coordinator

This block decides which processors of an N-processor shared-memory system must take a checkpoint together, or roll back together, and then coordinates the decision with them. Each processor keeps two dependence bitmaps: the processors whose data it consumed (its producers) and the processors that consumed its data (its consumers). On a start request, the coordinator captures the bitmap matrix that the operation needs. It then grows a member set outward from the initiating processor, one expansion per clock, until the set stops changing.

The finished set becomes the group. Every member receives one query strobe and answers on per-processor response lines with accept or decline. For a checkpoint, a single decline aborts the whole operation. When every member has accepted, the operation commits. A rollback cannot be refused: it commits once every member has responded. The outcome reaches all members as a one-cycle commit or abort strobe, together with a one-cycle done pulse that carries the result. Moving messages across an interconnect is left to the logic around this block.

Top module: `ckgc_top`

## Requirements
- R1: After reset, every strobe, `done_o`, `result_o` and `busy_o` is 0, and `group_o` is all zeros.
- R2: For a checkpoint (`op_i`=0), the group is the initiator plus every processor reachable from it by repeatedly following producer rows. Bit j of row i (flat bit i*N_PROC+j of `prod_map_i`) set means processor i consumed data produced by j. The matrices are captured on the edge that accepts `start_i`, and later changes to them have no effect on the operation.
- R3: For a rollback (`op_i`=1), the group is formed in the same way, but from the rows of `cons_map_i`.
- R4: Let D be the largest hop distance from the initiator to any group member. The query pulse is visible in the cycle that follows the (D+1)-th rising edge after the edge that accepted `start_i`.
- R5: `query_o` equals the group for exactly one cycle, so each member is queried exactly once per operation.
- R6: If every member accepts, `commit_o` equals the group and `done_o`=`result_o`=1 for exactly one cycle. This cycle directly follows the edge that samples the last outstanding response. `abort_o` stays 0.
- R7: During a checkpoint, a decline from a member whose answer is still outstanding ends the operation on the edge that samples it. `abort_o` equals the group, `done_o`=1 and `result_o`=0 for one cycle, and the other answers are not waited for.
- R8: During a rollback, declines count as answers. The operation commits once every member has answered and never aborts.
- R9: Responses from non-members, repeated responses, and responses present in the query cycle itself are ignored.
- R10: `start_i` is ignored while `busy_o` is 1. `busy_o` is 1 from the edge that accepts a start until the done cycle has passed.
- R11: `group_o` holds the most recently formed group from its query cycle until the next group is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| op_i | input | 1 | 0 = checkpoint, 1 = rollback |
| init_id_i | input | $clog2(N_PROC) | Initiating processor |
| prod_map_i | input | N_PROC*N_PROC | Producer rows, row i at bits i*N_PROC +: N_PROC |
| cons_map_i | input | N_PROC*N_PROC | Consumer rows, same layout |
| rsp_valid_i | input | N_PROC | Per-processor response present |
| rsp_accept_i | input | N_PROC | 1 = accept, 0 = decline |
| query_o | output | N_PROC | One-cycle query strobe per member |
| commit_o | output | N_PROC | One-cycle commit strobe per member |
| abort_o | output | N_PROC | One-cycle abort strobe per member |
| group_o | output | N_PROC | Last formed group |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 1 | With done: 1 = commit, 0 = abort |

## Verification
The query pulse is due D+1 edges after the start edge. The bench computes D with its own breadth-first search and counts falling-edge samples from the start edge until the query appears. The outcome is due exactly one edge after the response that settles it, so the bench drives each batch of responses on a falling edge and checks `done_o`, the result and both strobe vectors on the next falling edge, with `done_o` required to be 0 at every earlier sample. One more sample after the done cycle confirms that the pulse has ended, that the group is still held, and that `busy_o` has returned to 0.

// File: rtl/ckgc_pkg.sv
package ckgc_pkg;
   typedef enum logic [0:0] {
      OP_CKPT = 1'b0,
      OP_RBK  = 1'b1
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLOSE,
      ST_QUERY,
      ST_WAIT,
      ST_DONE
   } state_e;
endpackage

// File: rtl/ckgc_closure.sv
module ckgc_closure #(
   parameter int N_PROC     = 8,
   parameter bit LATCH_MAPS = 1'b1,
   localparam int IDW       = $clog2(N_PROC),
   localparam int MW        = N_PROC * N_PROC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              rbk_i,
   input  logic [IDW-1:0]    seed_id_i,
   input  logic [MW-1:0]     prod_map_i,
   input  logic [MW-1:0]     cons_map_i,
   output logic [N_PROC-1:0] set_o,
   output logic [N_PROC-1:0] next_o,
   output logic              grown_o
);
   initial assert (N_PROC >= 2 && N_PROC <= 64)
      else $error("ckgc_closure: N_PROC out of range");

   logic [MW-1:0]     sel_map;
   logic [N_PROC-1:0] set_q;
   logic [N_PROC-1:0] row_hit [N_PROC];
   logic [N_PROC-1:0] next_set;

   generate
      if (LATCH_MAPS) begin : g_latched
         logic [MW-1:0] map_q;
         logic [MW-1:0] live_sel;
         assign live_sel = rbk_i ? cons_map_i : prod_map_i;
         always_ff @(posedge clk) begin
            if (!rst_n)      map_q <= '0;
            else if (load_i) map_q <= live_sel;
         end
         assign sel_map = map_q;
      end else begin : g_live
         logic rbk_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      rbk_q <= 1'b0;
            else if (load_i) rbk_q <= rbk_i;
         end
         assign sel_map = rbk_q ? cons_map_i : prod_map_i;
      end
   endgenerate

   for (genvar gi = 0; gi < N_PROC; gi++) begin : g_row
      assign row_hit[gi] = set_q[gi] ? sel_map[gi*N_PROC +: N_PROC] : '0;
   end

   always_comb begin
      next_set = set_q;
      for (int i = 0; i < N_PROC; i++) next_set = next_set | row_hit[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      set_q <= '0;
      else if (load_i) set_q <= {{(N_PROC-1){1'b0}}, 1'b1} << seed_id_i;
      else if (step_i) set_q <= next_set;
   end

   assign set_o   = set_q;
   assign next_o  = next_set;
   assign grown_o = (next_set != set_q);

   // R2: an expansion step never drops a member already in the set
   p_set_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> ((set_q & $past(set_q)) == $past(set_q)));
endmodule

// File: rtl/ckgc_collect.sv
module ckgc_collect #(
   parameter int N_PROC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              open_i,
   input  logic              strict_i,
   input  logic [N_PROC-1:0] group_i,
   input  logic [N_PROC-1:0] rsp_valid_i,
   input  logic [N_PROC-1:0] rsp_accept_i,
   output logic              decline_o,
   output logic              all_in_o
);
   logic [N_PROC-1:0] pend_q;
   logic [N_PROC-1:0] pend_left;
   logic [N_PROC-1:0] refused;

   assign pend_left = pend_q & ~rsp_valid_i;
   assign refused   = pend_q & rsp_valid_i & ~rsp_accept_i;
   assign decline_o = open_i && strict_i && (refused != '0);
   assign all_in_o  = open_i && (pend_left == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      pend_q <= '0;
      else if (arm_i)  pend_q <= group_i;
      else if (open_i) pend_q <= pend_left;
   end

   // R9: outside arming, the outstanding set only shrinks
   p_pending_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/ckgc_top.sv
module ckgc_top
   import ckgc_pkg::*;
#(
   parameter int N_PROC     = 8,
   parameter bit LATCH_MAPS = 1'b1,
   localparam int IDW       = $clog2(N_PROC),
   localparam int MW        = N_PROC * N_PROC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_i,
   input  logic [IDW-1:0]    init_id_i,
   input  logic [MW-1:0]     prod_map_i,
   input  logic [MW-1:0]     cons_map_i,
   input  logic [N_PROC-1:0] rsp_valid_i,
   input  logic [N_PROC-1:0] rsp_accept_i,
   output logic [N_PROC-1:0] query_o,
   output logic [N_PROC-1:0] commit_o,
   output logic [N_PROC-1:0] abort_o,
   output logic [N_PROC-1:0] group_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              result_o
);
   initial assert (N_PROC >= 2 && N_PROC <= 64)
      else $error("ckgc_top: N_PROC out of range");

   state_e            st_q;
   op_e               op_q;
   logic [IDW-1:0]    init_q;
   logic [IDW-1:0]    iter_q;
   logic [N_PROC-1:0] group_q;
   logic              res_q;

   logic              load, step, close_end;
   logic [N_PROC-1:0] set_w, next_w;
   logic              grown_w, decline_w, all_in_w;

   assign load      = (st_q == ST_IDLE) && start_i;
   assign step      = (st_q == ST_CLOSE);
   assign close_end = step && (!grown_w || iter_q == IDW'(N_PROC-1));

   ckgc_closure #(.N_PROC(N_PROC), .LATCH_MAPS(LATCH_MAPS)) u_closure (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .step_i     (step),
      .rbk_i      (op_i),
      .seed_id_i  (init_id_i),
      .prod_map_i (prod_map_i),
      .cons_map_i (cons_map_i),
      .set_o      (set_w),
      .next_o     (next_w),
      .grown_o    (grown_w)
   );

   ckgc_collect #(.N_PROC(N_PROC)) u_collect (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (st_q == ST_QUERY),
      .open_i       (st_q == ST_WAIT),
      .strict_i     (op_q == OP_CKPT),
      .group_i      (group_q),
      .rsp_valid_i  (rsp_valid_i),
      .rsp_accept_i (rsp_accept_i),
      .decline_o    (decline_w),
      .all_in_o     (all_in_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= OP_CKPT;
         init_q  <= '0;
         iter_q  <= '0;
         group_q <= '0;
         res_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q   <= ST_CLOSE;
               op_q   <= op_e'(op_i);
               init_q <= init_id_i;
               iter_q <= '0;
            end
            ST_CLOSE: begin
               if (close_end) begin
                  group_q <= next_w;
                  st_q    <= ST_QUERY;
               end else begin
                  iter_q <= iter_q + 1'b1;
               end
            end
            ST_QUERY: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (decline_w) begin
                  res_q <= 1'b0;
                  st_q  <= ST_DONE;
               end else if (all_in_w) begin
                  res_q <= 1'b1;
                  st_q  <= ST_DONE;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign query_o  = (st_q == ST_QUERY) ? group_q : '0;
   assign done_o   = (st_q == ST_DONE);
   assign result_o = done_o && res_q;
   assign commit_o = (done_o && res_q)  ? group_q : '0;
   assign abort_o  = (done_o && !res_q) ? group_q : '0;
   assign group_o  = group_q;
   assign busy_o   = (st_q != ST_IDLE);

   // R6: completion is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R5: the query strobe never lasts two cycles
   p_query_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (query_o != '0) |=> (query_o == '0));
   // R6/R7: strobes reach members only, and never both kinds at once
   p_strobe_in_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (((commit_o | abort_o) & ~group_o) == '0) && ((commit_o & abort_o) == '0));
   // R8: a rollback never ends in abort
   p_rbk_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && op_q == OP_RBK) |-> result_o);
   // R2: the initiator is always part of its own group
   p_init_member_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (query_o != '0) |-> group_o[init_q]);
   // R10: the closure set stays put while no start is accepted and no step runs
   p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |=> $stable(set_w));
endmodule

// File: tb/tb_ckgc_top.sv
module tb_ckgc_top;
   localparam int N   = 8;
   localparam int IDW = $clog2(N);
   localparam int MW  = N * N;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start_i;
   logic          op_i;
   logic [IDW-1:0] init_id_i;
   logic [MW-1:0] prod_map_i, cons_map_i;
   logic [N-1:0]  rsp_valid_i, rsp_accept_i;
   logic [N-1:0]  query_o, commit_o, abort_o, group_o;
   logic          busy_o, done_o, result_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ckgc_top #(.N_PROC(N)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .init_id_i(init_id_i), .prod_map_i(prod_map_i), .cons_map_i(cons_map_i),
      .rsp_valid_i(rsp_valid_i), .rsp_accept_i(rsp_accept_i),
      .query_o(query_o), .commit_o(commit_o), .abort_o(abort_o),
      .group_o(group_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_group(input logic [MW-1:0] m,
                                              input int init, output int depth);
      logic [N-1:0] s, nx;
      s = '0;
      s[init] = 1'b1;
      depth = 0;
      for (int k = 0; k < N; k++) begin
         nx = s;
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               if (s[i] && m[i*N+j]) nx[j] = 1'b1;
         if (nx == s) break;
         s = nx;
         depth++;
      end
      return s;
   endfunction

   task automatic run_op(input bit op, input int init, input logic [MW-1:0] pm,
                         input logic [MW-1:0] cm, input logic [N-1:0] dec_mask,
                         input bit noise, input bit busy_start, input bit remap);
      logic [N-1:0] exp, pend, batch;
      int d, cnt;
      bit dec_now, early_done;
      exp = exp_group(op ? cm : pm, init, d);
      @(negedge clk);
      prod_map_i = pm; cons_map_i = cm; op_i = op; init_id_i = IDW'(init);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
      if (remap) begin prod_map_i = ~pm; cons_map_i = ~cm; end
      cnt = 0;
      while (cnt < 40) begin
         @(negedge clk);
         cnt++;
         if (query_o != '0) break;
      end
      chk(cnt == d + 1, "R4 query timing", 64'(cnt), 64'(d + 1));
      chk(query_o == exp, op ? "R3 rollback group" : "R2 checkpoint group",
          64'(query_o), 64'(exp));
      if (noise) begin
         rsp_valid_i = exp; rsp_accept_i = '0;   // R9: query-cycle answers ignored
      end
      @(negedge clk);
      rsp_valid_i = '0; rsp_accept_i = '0;
      chk(query_o == '0, "R5 single query pulse", 64'(query_o), 64'd0);
      if (busy_start) begin
         start_i = 1'b1; init_id_i = IDW'((init + 1) % N); prod_map_i = '1; cons_map_i = '1;
      end
      pend = exp;
      early_done = 1'b0;
      for (int t = 0; t < 300; t++) begin
         batch = pend & N'($urandom);
         rsp_valid_i  = batch | (noise ? (~exp & N'($urandom)) : '0);
         rsp_accept_i = ~dec_mask & exp;
         dec_now = (op == 1'b0) && ((batch & dec_mask) != '0);
         pend = pend & ~batch;
         @(negedge clk);
         start_i = 1'b0;
         rsp_valid_i = '0; rsp_accept_i = '0;
         if (dec_now) begin
            chk(done_o && !result_o, "R7 abort on decline", {62'd0, done_o, result_o}, 64'd2);
            chk(abort_o == exp && commit_o == '0, "R7 abort strobes", 64'(abort_o), 64'(exp));
            break;
         end else if (pend == '0) begin
            chk(done_o && result_o, op ? "R8 rollback commits" : "R6 commit",
                {62'd0, done_o, result_o}, 64'd3);
            chk(commit_o == exp && abort_o == '0, "R6 commit strobes", 64'(commit_o), 64'(exp));
            break;
         end else if (done_o) begin
            early_done = 1'b1;
         end
      end
      chk(!early_done, "R9 no early done", 64'(early_done), 64'd0);
      @(negedge clk);
      chk(!done_o && commit_o == '0 && abort_o == '0, "R6 done one cycle",
          64'(done_o), 64'd0);
      chk(group_o == exp, "R11 group held", 64'(group_o), 64'(exp));
      chk(!busy_o, "R10 idle after done (start while busy ignored)", 64'(busy_o), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [MW-1:0] chain, rchain, pm, cm;
      logic [N-1:0] dm;
      void'($urandom(32'd1234));
      rst_n = 1'b0; start_i = 1'b0; op_i = 1'b0; init_id_i = '0;
      prod_map_i = '0; cons_map_i = '0; rsp_valid_i = '0; rsp_accept_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(query_o == '0 && commit_o == '0 && abort_o == '0, "R1 strobes idle", 64'(query_o), 64'd0);
      chk(!busy_o && !done_o && !result_o, "R1 flags idle", {61'd0, busy_o, done_o, result_o}, 64'd0);
      chk(group_o == '0, "R1 group cleared", 64'(group_o), 64'd0);

      chain = '0; rchain = '0;
      for (int i = 0; i < N - 1; i++) chain[i*N + i + 1] = 1'b1;
      for (int i = 1; i < N; i++) rchain[i*N + i - 1] = 1'b1;
      // R2/R4 longest chain, all accept
      run_op(1'b0, 0, chain, '0, '0, 1'b0, 1'b0, 1'b0);
      // R3 rollback over consumer chain from the far end
      run_op(1'b1, N - 1, '0, rchain, '0, 1'b0, 1'b0, 1'b0);
      // R4 isolated initiator, D = 0
      run_op(1'b0, 3, '0, '1, '0, 1'b0, 1'b0, 1'b0);
      // R7 decline aborts
      run_op(1'b0, 0, chain, '0, 8'h10, 1'b0, 1'b0, 1'b0);
      // R8 rollback ignores declines
      run_op(1'b1, 2, '0, '1, '1, 1'b0, 1'b0, 1'b0);
      // R9 noise, R10 start while busy, R2 map change after start
      run_op(1'b0, 5, chain, rchain, '0, 1'b1, 1'b1, 1'b1);
      for (int k = 0; k < 60; k++) begin
         pm = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         cm = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         dm = ($urandom % 3 == 0) ? N'($urandom) & N'($urandom) : '0;
         run_op(1'($urandom), int'($urandom % N), pm, cm, dm,
                1'($urandom), 1'($urandom), 1'($urandom));
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule